// File: doc/BRIEF.md
# Accumulator ALU with Status Flags

This block is the execute stage of a small accumulator machine. It holds a 32-bit accumulator and four status flags: carry, zero, negative and overflow. While the one-cycle execute strobe is high, it applies a 4-bit operation code to the accumulator and to an operand that comes from memory. On that clock edge it writes the result back to the accumulator, except for the compare and bit-test operations, and it updates the flags.

All arithmetic goes through one shared adder that is one bit wider than the data. Subtract-class operations feed the complemented memory operand into the first adder input. The carry-in is chosen per operation: zero, one, or the stored carry flag. A parameter selects either an inferred adder or an explicit ripple chain built in a generate loop.

Operand fetch, addressing, sequencing and memory access stay with the surrounding control logic. The accumulator is loaded through the move operation.

Top module: `acc_alu`

## Requirements
- R1: After reset the accumulator and all four flags are 0.
- R2: Move (code 0010) loads the accumulator with the memory operand. It sets zero and negative from the loaded value and leaves carry and overflow unchanged.
- R3: Add (0101) writes accumulator + operand with carry-in 0. Add-with-carry (0100) uses the stored carry flag as carry-in. Carry takes bit 32 of the 33-bit sum.
- R4: Subtract (0001) writes accumulator + ~operand + 1. Subtract-with-carry (0000) writes accumulator + ~operand + stored carry. Carry takes bit 32 of the sum, so 1 means no borrow.
- R5: Compare (0011) sets all four flags exactly as subtract would and leaves the accumulator unchanged.
- R6: OR (1000), AND (1001) and XOR (1010) write the bitwise result to the accumulator and leave carry and overflow unchanged.
- R7: Bit-test (1011) sets zero and negative from accumulator AND operand. It leaves the accumulator, carry and overflow unchanged.
- R8: For every add/subtract-class code, overflow is 1 exactly when both adder inputs have the same sign bit (bit 31) and the sum's bit 31 differs from it.
- R9: On every defined code, zero is set exactly when all 32 result bits are 0, and negative copies result bit 31.
- R10: With the execute strobe low, the accumulator and all flags keep their values.
- R11: Undefined codes (0110, 0111, 1100 to 1111) leave the accumulator and all flags unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| exec_en | input | 1 | Execute strobe, one cycle per operation |
| op_code | input | 4 | Operation code |
| mem_opnd | input | 32 | Memory operand |
| acc_q | output | 32 | Accumulator |
| flag_c | output | 1 | Carry flag |
| flag_z | output | 1 | Zero flag |
| flag_n | output | 1 | Negative flag |
| flag_v | output | 1 | Overflow flag |

## Verification
The assertions assume that the operation code and the operand are stable across the sampling edge and carry no unknown bits while the strobe is high. They also assume the strobe is low during reset. The stimulus changes inputs only on the falling clock edge. It draws codes from all sixteen values, so undefined codes are covered, and it keeps the strobe high most of the time. Directed cases target signed overflow, borrow, equal compare and carry chaining, which the random draws rarely reach.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

   localparam logic [3:0] OP_SUBB = 4'b0000;
   localparam logic [3:0] OP_SUB  = 4'b0001;
   localparam logic [3:0] OP_MOVE = 4'b0010;
   localparam logic [3:0] OP_CMP  = 4'b0011;
   localparam logic [3:0] OP_ADDC = 4'b0100;
   localparam logic [3:0] OP_ADD  = 4'b0101;
   localparam logic [3:0] OP_OR   = 4'b1000;
   localparam logic [3:0] OP_AND  = 4'b1001;
   localparam logic [3:0] OP_XOR  = 4'b1010;
   localparam logic [3:0] OP_TEST = 4'b1011;

   typedef enum logic [1:0] {CIN_ZERO, CIN_ONE, CIN_FLAG} cin_sel_e;
   typedef enum logic [2:0] {RES_SUM, RES_PASS, RES_OR, RES_AND, RES_XOR} res_sel_e;

   typedef struct packed {
      logic     valid;
      logic     inv_opnd;
      cin_sel_e cin_sel;
      res_sel_e res_sel;
      logic     wr_acc;
      logic     upd_cv;
   } ctrl_t;

endpackage

// File: rtl/acc_alu_decode.sv
module acc_alu_decode
   import acc_alu_pkg::*;
(
   input  logic [3:0] op_code,
   output ctrl_t      ctrl
);
   always_comb begin
      ctrl = '{valid: 1'b1, inv_opnd: 1'b0, cin_sel: CIN_ZERO,
               res_sel: RES_SUM, wr_acc: 1'b1, upd_cv: 1'b0};
      case (op_code)
         OP_SUBB: begin ctrl.inv_opnd = 1'b1; ctrl.cin_sel = CIN_FLAG; ctrl.upd_cv = 1'b1; end
         OP_SUB:  begin ctrl.inv_opnd = 1'b1; ctrl.cin_sel = CIN_ONE;  ctrl.upd_cv = 1'b1; end
         OP_CMP:  begin ctrl.inv_opnd = 1'b1; ctrl.cin_sel = CIN_ONE;  ctrl.upd_cv = 1'b1;
                        ctrl.wr_acc = 1'b0; end
         OP_ADDC: begin ctrl.cin_sel = CIN_FLAG; ctrl.upd_cv = 1'b1; end
         OP_ADD:  begin ctrl.upd_cv = 1'b1; end
         OP_MOVE: ctrl.res_sel = RES_PASS;
         OP_OR:   ctrl.res_sel = RES_OR;
         OP_AND:  ctrl.res_sel = RES_AND;
         OP_XOR:  ctrl.res_sel = RES_XOR;
         OP_TEST: begin ctrl.res_sel = RES_AND; ctrl.wr_acc = 1'b0; end
         default: begin ctrl.valid = 1'b0; ctrl.wr_acc = 1'b0; end
      endcase
   end
endmodule

// File: rtl/acc_alu_datapath.sv
module acc_alu_datapath
   import acc_alu_pkg::*;
#(
   parameter int WIDTH  = 32,
   parameter bit RIPPLE = 1'b0
)(
   input  ctrl_t            ctrl,
   input  logic [WIDTH-1:0] mem_opnd,
   input  logic [WIDTH-1:0] acc,
   input  logic             carry_flag,
   output logic [WIDTH-1:0] result,
   output logic             cout,
   output logic             ovf
);
   localparam int MSB = WIDTH - 1;

   logic [WIDTH-1:0] add_a;
   logic [WIDTH-1:0] sum;
   logic             cin;

   assign add_a = ctrl.inv_opnd ? ~mem_opnd : mem_opnd;

   always_comb begin
      case (ctrl.cin_sel)
         CIN_ONE:  cin = 1'b1;
         CIN_FLAG: cin = carry_flag;
         default:  cin = 1'b0;
      endcase
   end

   generate
      if (RIPPLE) begin : g_ripple
         logic [WIDTH:0] chain;
         assign chain[0] = cin;
         for (genvar i = 0; i < WIDTH; i++) begin : g_bit
            assign sum[i]      = add_a[i] ^ acc[i] ^ chain[i];
            assign chain[i+1]  = (add_a[i] & acc[i]) | (chain[i] & (add_a[i] ^ acc[i]));
         end
         assign cout = chain[WIDTH];
      end else begin : g_infer
         logic [WIDTH:0] wide;
         assign wide = {1'b0, add_a} + {1'b0, acc} + {{WIDTH{1'b0}}, cin};
         assign sum  = wide[MSB:0];
         assign cout = wide[WIDTH];
      end
   endgenerate

   assign ovf = (add_a[MSB] == acc[MSB]) && (sum[MSB] != add_a[MSB]);

   always_comb begin
      case (ctrl.res_sel)
         RES_PASS: result = mem_opnd;
         RES_OR:   result = mem_opnd | acc;
         RES_AND:  result = mem_opnd & acc;
         RES_XOR:  result = mem_opnd ^ acc;
         default:  result = sum;
      endcase
   end
endmodule

// File: rtl/acc_alu_state.sv
module acc_alu_state
   import acc_alu_pkg::*;
#(
   parameter int WIDTH = 32
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             exec_en,
   input  ctrl_t            ctrl,
   input  logic [WIDTH-1:0] result,
   input  logic             cout,
   input  logic             ovf,
   output logic [WIDTH-1:0] acc_q,
   output logic             flag_c,
   output logic             flag_z,
   output logic             flag_n,
   output logic             flag_v
);
   localparam int MSB = WIDTH - 1;

   logic fire;
   assign fire = exec_en && ctrl.valid;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q  <= '0;
         flag_c <= 1'b0;
         flag_z <= 1'b0;
         flag_n <= 1'b0;
         flag_v <= 1'b0;
      end else if (fire) begin
         if (ctrl.wr_acc) acc_q <= result;
         if (ctrl.upd_cv) begin
            flag_c <= cout;
            flag_v <= ovf;
         end
         flag_z <= (result == '0);
         flag_n <= result[MSB];
      end
   end

   // R10
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !exec_en |=> $stable(acc_q) && $stable({flag_c, flag_z, flag_n, flag_v}));

   // R11
   undef_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (exec_en && !ctrl.valid) |=> $stable(acc_q) && $stable({flag_c, flag_z, flag_n, flag_v}));

   // R5 R7
   no_writeback_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && !ctrl.wr_acc) |=> $stable(acc_q));

   // R9
   zn_match_acc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && ctrl.wr_acc) |=> (flag_z == (acc_q == '0)) && (flag_n == acc_q[MSB]));

   // R6
   cv_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && !ctrl.upd_cv) |=> $stable({flag_c, flag_v}));
endmodule

// File: rtl/acc_alu.sv
module acc_alu
   import acc_alu_pkg::*;
#(
   parameter int WIDTH  = 32,
   parameter bit RIPPLE = 1'b0
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             exec_en,
   input  logic [3:0]       op_code,
   input  logic [WIDTH-1:0] mem_opnd,
   output logic [WIDTH-1:0] acc_q,
   output logic             flag_c,
   output logic             flag_z,
   output logic             flag_n,
   output logic             flag_v
);
   generate
      if (WIDTH < 2) begin : g_bad_width
         $error("acc_alu: WIDTH must be at least 2");
      end
   endgenerate

   ctrl_t            ctrl;
   logic [WIDTH-1:0] result;
   logic             cout;
   logic             ovf;

   acc_alu_decode u_decode (
      .op_code (op_code),
      .ctrl    (ctrl)
   );

   acc_alu_datapath #(.WIDTH(WIDTH), .RIPPLE(RIPPLE)) u_datapath (
      .ctrl       (ctrl),
      .mem_opnd   (mem_opnd),
      .acc        (acc_q),
      .carry_flag (flag_c),
      .result     (result),
      .cout       (cout),
      .ovf        (ovf)
   );

   acc_alu_state #(.WIDTH(WIDTH)) u_state (
      .clk     (clk),
      .rst_n   (rst_n),
      .exec_en (exec_en),
      .ctrl    (ctrl),
      .result  (result),
      .cout    (cout),
      .ovf     (ovf),
      .acc_q   (acc_q),
      .flag_c  (flag_c),
      .flag_z  (flag_z),
      .flag_n  (flag_n),
      .flag_v  (flag_v)
   );
endmodule

// File: tb/acc_alu_bench.sv
module acc_alu_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        exec_en = 1'b0;
   logic [3:0]  op_code = 4'h0;
   logic [31:0] mem_opnd = '0;
   logic [31:0] acc_q;
   logic        flag_c, flag_z, flag_n, flag_v;

   int n_checks = 0;
   int n_fail   = 0;
   bit finished = 1'b0;

   logic [31:0] m_acc = '0;
   logic        m_c = 1'b0, m_z = 1'b0, m_n = 1'b0, m_v = 1'b0;

   always #4 clk = ~clk;

   acc_alu u_acc_alu (
      .clk(clk), .rst_n(rst_n), .exec_en(exec_en), .op_code(op_code),
      .mem_opnd(mem_opnd), .acc_q(acc_q), .flag_c(flag_c), .flag_z(flag_z),
      .flag_n(flag_n), .flag_v(flag_v)
   );

   function automatic string tag_of(input logic en, input logic [3:0] op);
      if (!en) return "R10";
      case (op)
         4'b0010: return "R2";
         4'b0100, 4'b0101: return "R3";
         4'b0000, 4'b0001: return "R4";
         4'b0011: return "R5";
         4'b1000, 4'b1001, 4'b1010: return "R6";
         4'b1011: return "R7";
         default: return "R11";
      endcase
   endfunction

   task automatic compare(input string tag);
      logic [35:0] act, exp;
      act = {acc_q, flag_c, flag_z, flag_n, flag_v};
      exp = {m_acc, m_c, m_z, m_n, m_v};
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: acc/c/z/n/v actual %h %b%b%b%b expected %h %b%b%b%b", tag,
                  acc_q, flag_c, flag_z, flag_n, flag_v, m_acc, m_c, m_z, m_n, m_v);
      end
   endtask

   task automatic do_op(input logic en, input logic [3:0] op, input logic [31:0] m,
                        input string tag);
      logic        inv, cin, valid, wr, cv;
      logic [31:0] a, res;
      logic [32:0] s;
      @(negedge clk);
      exec_en = en; op_code = op; mem_opnd = m;
      inv   = (op == 4'b0000) || (op == 4'b0001) || (op == 4'b0011);
      a     = inv ? ~m : m;
      cin   = (op == 4'b0101) ? 1'b0 : ((op == 4'b0001 || op == 4'b0011) ? 1'b1 : m_c);
      s     = {1'b0, a} + {1'b0, m_acc} + {32'd0, cin};
      cv    = (op == 4'b0000) || (op == 4'b0001) || (op == 4'b0011) ||
              (op == 4'b0100) || (op == 4'b0101);
      valid = cv || (op == 4'b0010) || (op == 4'b1000) || (op == 4'b1001) ||
              (op == 4'b1010) || (op == 4'b1011);
      case (op)
         4'b0010: res = m;
         4'b1000: res = m | m_acc;
         4'b1001, 4'b1011: res = m & m_acc;
         4'b1010: res = m ^ m_acc;
         default: res = s[31:0];
      endcase
      wr = valid && (op != 4'b0011) && (op != 4'b1011);
      if (en && valid) begin
         if (cv) begin
            m_c = s[32];
            m_v = (a[31] == m_acc[31]) && (s[31] != a[31]);
         end
         m_z = (res == 32'd0);
         m_n = res[31];
         if (wr) m_acc = res;
      end
      @(posedge clk);
      #1;
      compare(tag.len() > 0 ? tag : tag_of(en, op));
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240607));
      repeat (3) @(negedge clk);
      compare("R1");
      rst_n = 1'b1;
      // R2 load, R8 signed overflow on add
      do_op(1, 4'b0010, 32'h7FFF_FFFF, "");
      do_op(1, 4'b0101, 32'h0000_0001, "R8");
      // R4 equal subtract gives zero, carry 1
      do_op(1, 4'b0010, 32'h0000_1234, "");
      do_op(1, 4'b0001, 32'h0000_1234, "R9");
      // borrow: 0 - 1
      do_op(1, 4'b0001, 32'h0000_0001, "R4");
      // R3 carry chain: add with carry-out then add-with-carry
      do_op(1, 4'b0010, 32'hFFFF_FFFF, "");
      do_op(1, 4'b0101, 32'h0000_0001, "R3");
      do_op(1, 4'b0100, 32'h0000_0000, "R3");
      // R5 compare smaller operand, then negative minus positive overflow
      do_op(1, 4'b0011, 32'h0000_0000, "R5");
      do_op(1, 4'b0010, 32'h8000_0000, "");
      do_op(1, 4'b0011, 32'h0000_0001, "R8");
      do_op(1, 4'b0000, 32'h0000_0001, "R8");
      // R7 test with zero result, R6 logic ops
      do_op(1, 4'b1011, 32'h0000_0000, "R7");
      do_op(1, 4'b1000, 32'h0F0F_0000, "R6");
      do_op(1, 4'b1010, 32'hFFFF_FFFF, "R6");
      do_op(1, 4'b1001, 32'h0000_00FF, "R6");
      // R10 idle, R11 undefined codes
      do_op(0, 4'b0010, 32'hDEAD_BEEF, "R10");
      for (int k = 6; k < 16; k++)
         if (k == 6 || k == 7 || k >= 12) do_op(1, k[3:0], 32'hCAFE_F00D, "R11");
      for (int i = 0; i < 600; i++) begin
         logic [31:0] m;
         case ($urandom % 4)
            0: m = 32'h0000_0000;
            1: m = 32'h8000_0000 | ($urandom % 4);
            2: m = 32'h7FFF_FFFF - ($urandom % 4);
            default: m = $urandom;
         endcase
         do_op(($urandom % 10) != 0, 4'($urandom), m, "");
      end
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule